// File: doc/BRIEF.md
# TDM Receive Subchannel Slot Demultiplexer

This block takes a serial TDM receive stream, one bit per bit-clock cycle, together with a frame sync pulse. It walks a 16-entry time-slot table. A group of one or more chained entries describes each 8-bit slot. Every entry holds a per-bit mask, so one slot can be shared bit by bit among several logical channels. Each received bit goes to the first entry in its slot group whose mask claims that bit position. That entry's channel shifts the bit into its own accumulator.

When a channel has gathered eight accepted bits, the block raises a one-cycle byte strobe. The strobe carries the channel's 11-bit parameter address and the assembled byte. Software loads the table through a simple write port while the receiver is disabled, then enables the receiver. Reception starts at the first frame sync.

Top module: `tdm_subch_rx`

## Requirements
- R1: After reset, and in the cycle after any cycle with `rx_en` low, `byte_vld` is 0. Reset clears the table, all channel accumulators and the walk position.
- R2: A table entry is 16 bits: [15] valid, [14] wrap, [13] last-of-slot, [12:8] channel number, [7:0] mask. Mask bit p belongs to the p-th bit received in the slot, where bit 0 is received first. An entry with mask 0xFF gives one channel the whole slot.
- R3: Within a slot group, each bit goes to the first entry (in table order) whose mask bit for that position is 1. A group runs from its first entry up to and including the first entry with last or wrap set, and spans at most 8 entries.
- R4: A bit position that no entry in its group claims is dropped. It changes no channel's bit count.
- R5: A bit claimed by an entry whose valid bit is 0 is consumed and delivered to no channel. It changes no channel's bit count.
- R6: Each channel collects its accepted bits, with the first-received bit ending up in the MSB. On its 8th accepted bit, in the next cycle, `byte_vld` pulses for one cycle. At the same time `byte_addr` = {channel number, 6'b0} and `byte_data` holds the byte.
- R7: A bit sampled with `fsync` high is bit 0 of the slot that begins at entry 0, even if it arrives mid-frame. Before the first frame sync, and after a slot whose group ends with a wrap entry, bits are ignored until the next `fsync`.
- R8: `cfg_we` writes `cfg_entry` into entry `cfg_idx` only while `rx_en` is low. While the receiver is enabled, the write has no effect.
- R9: Driving `rx_en` low discards every partial byte and the walk position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| rx_bit | input | 1 | Serial receive data |
| fsync | input | 1 | Frame sync, marks the first bit of a frame |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Table entry index |
| cfg_entry | input | 16 | Table entry value |
| byte_vld | output | 1 | Byte-ready strobe |
| byte_addr | output | 11 | Channel parameter address |
| byte_data | output | 8 | Assembled byte |

## Verification
The first pattern uses full-mask entries, one channel per slot. It separates plain byte assembly and address forming from any subchannel handling. Split masks, both nibble-wise and alternating-bit, show that ownership follows the first claiming entry. Tables with unclaimed positions and with invalid entries show that dropped bits leave the counts untouched. A separate set of runs covers the edges of the frame walk. These runs stop a frame at a wrap entry with no fsync after it, resync mid-frame, write the table while enabled, and disable the receiver in the middle of a byte. Each of these can only be told apart from the plain case by where later bytes start.

// File: rtl/tdm_subch_rx.sv
module tdm_subch_rx #(
  parameter int N_ENT  = 16,
  parameter int CH_W   = 5,
  parameter int ADDR_W = 11,
  parameter int LOOK   = 8,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int ENT_W = 3 + CH_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_bit,
  input  logic              fsync,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ENT_W-1:0]  cfg_entry,
  output logic              byte_vld,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data
);
  localparam int NCH   = 1 << CH_W;
  localparam int LOW_W = ADDR_W - CH_W;
  localparam int K_W   = (LOOK > 1) ? $clog2(LOOK) : 1;
  localparam int F_V   = ENT_W - 1;
  localparam int F_W   = ENT_W - 2;
  localparam int F_L   = ENT_W - 3;

  logic [N_ENT-1:0][ENT_W-1:0] tbl;
  logic [IDX_W-1:0]            base;
  logic [2:0]                  pos;
  logic                        synced;
  logic [NCH-1:0][2:0]         cnt;
  logic [NCH-1:0][7:0]         sh;

  wire             active = rx_en & (fsync | synced);
  wire [IDX_W-1:0] cb     = fsync ? '0 : base;
  wire [2:0]       cp     = fsync ? 3'd0 : pos;

  logic [LOOK-1:0][ENT_W-1:0] win;
  logic [LOOK-1:0]            alive;
  logic                       own_hit;
  logic [K_W-1:0]             own_k, gend;
  logic [ENT_W-1:0]           own_e;
  logic                       end_wrap;
  logic [CH_W-1:0]            own_ch;
  logic                       own_valid;

  always_comb begin
    for (int k = 0; k < LOOK; k++) begin
      win[k] = tbl[cb + IDX_W'(k)];
      if (k == 0) alive[k] = 1'b1;
      else        alive[k] = alive[k-1] & ~(win[k-1][F_W] | win[k-1][F_L]);
    end
    own_hit = 1'b0;
    own_k   = '0;
    gend    = K_W'(LOOK - 1);
    for (int k = LOOK - 1; k >= 0; k--) begin
      if (alive[k] && win[k][cp]) begin
        own_hit = 1'b1;
        own_k   = K_W'(k);
      end
      if (alive[k] && (win[k][F_W] || win[k][F_L])) gend = K_W'(k);
    end
  end

  assign own_e     = win[own_k];
  assign own_ch    = own_e[8 +: CH_W];
  assign own_valid = own_e[F_V];
  assign end_wrap  = win[gend][F_W];

  wire take = active & own_hit & own_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl       <= '0;
      base      <= '0;
      pos       <= '0;
      synced    <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      byte_vld  <= 1'b0;
      byte_addr <= '0;
      byte_data <= '0;
    end else if (!rx_en) begin
      if (cfg_we) tbl[cfg_idx] <= cfg_entry;
      base     <= '0;
      pos      <= '0;
      synced   <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (active) begin
        if (cp == 3'd7) begin
          pos <= '0;
          if (end_wrap) begin
            synced <= 1'b0;
            base   <= '0;
          end else begin
            synced <= 1'b1;
            base   <= cb + IDX_W'(gend) + IDX_W'(1);
          end
        end else begin
          pos    <= cp + 3'd1;
          synced <= 1'b1;
          base   <= cb;
        end
      end
      if (take) begin
        sh[own_ch]  <= {sh[own_ch][6:0], rx_bit};
        cnt[own_ch] <= cnt[own_ch] + 3'd1;
        if (cnt[own_ch] == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_addr <= {own_ch, {LOW_W{1'b0}}};
          byte_data <= {sh[own_ch][6:0], rx_bit};
        end
      end
    end
  end

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !byte_vld);
  a_r7_idle_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !fsync) |=> !byte_vld);
  a_r4_unclaimed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && active && !own_hit) |=> $stable(cnt));
  a_r5_invalid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && active && own_hit && !own_valid) |=> ($stable(cnt) && !byte_vld));
  a_r8_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en)) |-> $stable(tbl));
  a_r6_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(take));
endmodule

// File: tb/tdm_subch_rx_tb.sv
module tdm_subch_rx_tb_top;
  localparam int CLK_T = 10;

  logic        clk = 0, rst_n = 0, rx_en = 0, rx_bit = 0, fsync = 0, cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic [15:0] cfg_entry = 0;
  logic        byte_vld;
  logic [10:0] byte_addr;
  logic [7:0]  byte_data;

  int checks = 0, fails = 0;
  string req = "R1";

  tdm_subch_rx dut_i (.clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
    .fsync(fsync), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry),
    .byte_vld(byte_vld), .byte_addr(byte_addr), .byte_data(byte_data));

  always #(CLK_T/2) clk = ~clk;

  int m_tbl[16];
  int m_base, m_pos, m_sync;
  int m_cnt[32];
  int m_sh[32];
  int e_vld, e_addr, e_data;
  int lfsr = 32'h1ACE;

  function automatic void model_clear();
    m_base = 0; m_pos = 0; m_sync = 0;
    for (int c = 0; c < 32; c++) begin m_cnt[c] = 0; m_sh[c] = 0; end
  endfunction

  function automatic void model_step(int en, int b, int fs, int we, int idx, int ent);
    int cb, cp, owner, gend, stop, e, ch;
    e_vld = 0;
    if (!en) begin
      if (we) m_tbl[idx] = ent;
      model_clear();
      return;
    end
    if (!(fs || m_sync)) return;
    cb = fs ? 0 : m_base;
    cp = fs ? 0 : m_pos;
    owner = -1; gend = 7; stop = 0;
    for (int k = 0; k < 8 && !stop; k++) begin
      e = m_tbl[(cb + k) % 16];
      if (owner < 0 && ((e >> cp) & 1)) owner = k;
      if ((e >> 13) & 3) begin gend = k; stop = 1; end
    end
    if (owner >= 0) begin
      e = m_tbl[(cb + owner) % 16];
      if ((e >> 15) & 1) begin
        ch = (e >> 8) & 31;
        m_sh[ch] = ((m_sh[ch] << 1) | b) & 255;
        m_cnt[ch]++;
        if (m_cnt[ch] == 8) begin
          m_cnt[ch] = 0;
          e_vld = 1; e_addr = ch * 64; e_data = m_sh[ch];
        end
      end
    end
    if (cp == 7) begin
      m_pos = 0;
      if ((m_tbl[(cb + gend) % 16] >> 14) & 1) begin m_sync = 0; m_base = 0; end
      else begin m_sync = 1; m_base = (cb + gend + 1) % 16; end
    end else begin
      m_pos = cp + 1; m_sync = 1; m_base = cb;
    end
  endfunction

  task automatic compare();
    checks++;
    if (byte_vld !== e_vld[0] || (e_vld != 0 &&
        (byte_addr !== e_addr[10:0] || byte_data !== e_data[7:0]))) begin
      fails++;
      $display("FAIL %s: vld/addr/data %0b/%h/%h expected %0d/%h/%h",
               req, byte_vld, byte_addr, byte_data, e_vld, e_addr, e_data);
    end
  endtask

  task automatic step(int en, int b, int fs, int we = 0, int idx = 0, int ent = 0);
    @(negedge clk);
    compare();
    rx_en = en[0]; rx_bit = b[0]; fsync = fs[0];
    cfg_we = we[0]; cfg_idx = idx[3:0]; cfg_entry = ent[15:0];
    model_step(en, b, fs, we, idx, ent);
  endtask

  function automatic int nextbit();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    return lfsr & 1;
  endfunction

  task automatic load(int idx, int ent);
    step(0, 0, 0, 1, idx, ent);
  endtask

  task automatic wipe();
    for (int i = 0; i < 16; i++) load(i, 0);
  endtask

  task automatic frames(int n, int len);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < len; i++) step(1, nextbit(), i == 0);
  endtask

  task automatic settle();
    step(0, 0, 0); step(0, 0, 0);
  endtask

  initial begin
    #(CLK_T * 200000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_tbl[i] = 0;
    model_clear();
    e_vld = 0; e_addr = 0; e_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1";
    step(0, 0, 0); step(0, 1, 0); step(1, 1, 1); step(1, 0, 0);
    settle();

    req = "R2/R6";
    load(0, 16'hA3FF); load(1, 16'hF1FF);
    frames(6, 16); settle();

    req = "R3";
    wipe();
    load(0, 16'h81F0); load(1, 16'hA20F); load(2, 16'h84AA); load(3, 16'hE555);
    frames(8, 16); settle();

    req = "R3-chain";
    wipe();
    load(0, 16'h8B03); load(1, 16'h8C0F); load(2, 16'hADFF); load(3, 16'hEEFF);
    frames(8, 16); settle();

    req = "R4";
    wipe();
    load(0, 16'hA63C); load(1, 16'hE701);
    frames(10, 16); settle();

    req = "R5";
    wipe();
    load(0, 16'h28FF); load(1, 16'h89F0); load(2, 16'hA90F); load(3, 16'hE9FF);
    frames(6, 24); settle();

    req = "R7";
    wipe();
    load(0, 16'hEAFF);
    for (int i = 0; i < 12; i++) step(1, 1, 0);
    for (int f = 0; f < 6; f++) begin
      for (int i = 0; i < 8; i++) step(1, nextbit(), i == 0);
      for (int i = 0; i < 9; i++) step(1, 1, 0);
    end
    frames(3, 5);
    frames(2, 8);
    settle();

    req = "R8";
    wipe();
    load(0, 16'hABFF); load(1, 16'hECFF);
    step(1, nextbit(), 1);
    for (int i = 1; i < 16; i++) step(1, nextbit(), 0, 1, i % 2, 16'hBF0F);
    frames(4, 16); settle();

    req = "R9";
    for (int i = 0; i < 13; i++) step(1, nextbit(), i == 0);
    step(0, 0, 0);
    frames(4, 16);
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule